// File: doc/BRIEF.md
# Dual Simultaneous-Sampling Converter Interface

This block models the digital side of a two-converter, simultaneous-sampling front end with 12-bit results. A falling edge on the active-low start strobe freezes the A and B sample inputs together. The block then runs a conversion that is paced by a conversion-clock enable pulse. When the conversion ends, both results go into a bank of four result registers: A and B for channel pair 0, and A and B for channel pair 1. A pair-select bit picks which pair a conversion writes.

A host reads the results over a parallel port that has an active-low chip-select and an active-low read strobe. A read pointer alternates between the A and B converter on every read-strobe falling edge. The pair-select bit at read time picks channel 0 or 1. The strobe pins are asynchronous and pass through a synchroniser inside the block. The conversion-clock enable and the two sample buses are synchronous to the system clock. The bus has a separate output-enable rather than tri-state pins.

Top module: `dualsamp_ctrl`

## Requirements
- R1: After reset, busy and dout_oe are 0, dout is 0, all four result registers hold 0, and the read pointer selects the A converter.
- R2: An accepted start captures samp_a and samp_b in the same cycle. Later changes on those inputs have no effect on the result of that conversion.
- R3: Busy rises on the third rising clock edge after conv_start_n is driven low from a non-busy state (two synchroniser stages plus one register).
- R4: The first conv_tick pulse after an accepted start begins the conversion and latches pair_sel. A value of 0 targets slots A0/B0 and 1 targets A1/B1. Later changes of pair_sel do not redirect the conversion.
- R5: Busy stays high through 13 conv_tick pulses, counting the first. On the 14th pulse the results are written and busy falls. The remaining 2 ticks of the 16-tick throughput period are acquisition time that the caller allows before the next start.
- R6: A finished conversion writes only the two slots of its latched pair. The slots of the other pair keep their previous values.
- R7: dout_oe is 1 only while both cs_n and rd_n are low. In every other combination dout_oe is 0 and dout is 0.
- R8: The first rd_n falling edge after an accepted start presents the A result of the pair chosen by pair_sel at read time. The next edge presents the B result, and later edges keep alternating.
- R9: A falling edge of rd_n advances the A/B pointer even when cs_n is high. A later selected read therefore returns the other converter's data.
- R10: A start edge that arrives while busy is high is ignored. The samples are not recaptured, the read pointer is not reset, and busy ends on the original tick count.
- R11: Results are 12-bit two's complement and pass through unchanged. Full-scale 0x7FF, midscale 0x000, midscale minus one 0xFFF and negative full-scale 0x800 all read back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_n | input | 1 | Asynchronous start strobe, a falling edge starts a conversion |
| pair_sel | input | 1 | Asynchronous channel-pair select (0: pair 0, 1: pair 1) |
| conv_tick | input | 1 | One-cycle conversion-clock enable, synchronous to clk |
| cs_n | input | 1 | Asynchronous active-low chip select |
| rd_n | input | 1 | Asynchronous active-low read strobe |
| samp_a | input | 12 | Converter A sample value, synchronous to clk |
| samp_b | input | 12 | Converter B sample value, synchronous to clk |
| busy | output | 1 | High while a conversion is in progress |
| dout | output | 12 | Read data, zero when not enabled |
| dout_oe | output | 1 | Read-port output enable |

## Verification
The properties assume the following about the inputs:
- conv_tick is a single-cycle pulse in the clk domain.
- Each asynchronous pin holds a new level for longer than the synchroniser depth.
- A start edge and a read edge each reduce to a one-cycle pulse.

The stimulus meets these conditions in three ways:
- It changes pins only at falling clock edges.
- It keeps every strobe level for at least four cycles.
- It separates ticks by an idle cycle.

It sets pair_sel three cycles before any tick or read edge that depends on it. Outside the R2 and R10 cases, it changes the sample buses only before a start.

// File: rtl/dsc_pkg.sv
// Package: shared types and slot indexing for the converter interface.
// Assumes four result slots addressed as {pair, converter}, converter 0 = A.
package dsc_pkg;

    localparam int unsigned NUM_SLOTS = 4;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HOLD = 2'd1,
        SQ_CONV = 2'd2
    } seq_state_t;

    // Slot index of a result: pair in the upper bit, converter in the lower.
    function automatic logic [1:0] slot_of(input logic pair, input logic conv_b);
        return {pair, conv_b};
    endfunction

endpackage

// File: rtl/dsc_sync.sv
// Module: multi-bit level synchroniser for asynchronous control pins.
// Each bit is independent; assumes pins are quasi-static relative to STAGES.
module dsc_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pin levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/dsc_seq.sv
// Module: conversion sequencer. Captures both samples on an accepted start,
// waits for the first conversion tick (latching the pair), counts CONV_TICKS
// ticks and issues one write. Assumes tick is a one-cycle pulse, CONV_TICKS >= 2.
module dsc_seq
    import dsc_pkg::*;
#(
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned CONV_TICKS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_fall,
    input  logic              tick,
    input  logic              pair_s,
    input  logic [DATA_W-1:0] samp_a,
    input  logic [DATA_W-1:0] samp_b,
    output logic              busy,
    output logic              accept,
    output logic              wr_en,
    output logic              wr_pair,
    output logic [DATA_W-1:0] wr_a,
    output logic [DATA_W-1:0] wr_b
);

    localparam int unsigned CNT_W = $clog2(CONV_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_TICKS - 1);

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic              pair_l;
    logic [DATA_W-1:0] hold_a;
    logic [DATA_W-1:0] hold_b;

    // Hold, pair latch and tick counting for one conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            cnt    <= '0;
            pair_l <= 1'b0;
            hold_a <= '0;
            hold_b <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_fall) begin
                        hold_a <= samp_a;
                        hold_b <= samp_b;
                        state  <= SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (tick) begin
                        pair_l <= pair_s;
                        cnt    <= CNT_W'(1);
                        state  <= SQ_CONV;
                    end
                end
                SQ_CONV: begin
                    if (tick) begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            state <= SQ_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Decode status and the single-cycle result write.
    always_comb begin
        busy    = (state != SQ_IDLE);
        accept  = start_fall && (state == SQ_IDLE);
        wr_en   = (state == SQ_CONV) && tick && (cnt == LAST);
        wr_pair = pair_l;
        wr_a    = hold_a;
        wr_b    = hold_b;
    end

endmodule

// File: rtl/dsc_bank.sv
// Module: four-slot result bank with the A/B read pointer and registered
// read port. Assumes rd_fall and accept are one-cycle pulses.
module dsc_bank
    import dsc_pkg::*;
#(
    parameter int unsigned DATA_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_pair,
    input  logic [DATA_W-1:0]             wr_a,
    input  logic [DATA_W-1:0]             wr_b,
    input  logic                          accept,
    input  logic                          rd_fall,
    input  logic                          rd_active,
    input  logic                          pair_s,
    output logic [DATA_W-1:0]             dout,
    output logic                          dout_oe,
    output logic                          rd_ptr,
    output logic [NUM_SLOTS*DATA_W-1:0]   bank_flat
);

    logic [DATA_W-1:0] slot [NUM_SLOTS];
    logic              sel_q;
    logic              ptr_base;
    logic              sel_now;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic SLOT_PAIR = 1'(g / 2);
        localparam logic SLOT_B    = 1'(g % 2);
        // Load this slot when its pair completes a conversion.
        always_ff @(posedge clk) begin
            if (!rst_n)                            slot[g] <= '0;
            else if (wr_en && wr_pair == SLOT_PAIR) slot[g] <= SLOT_B ? wr_b : wr_a;
        end
        assign bank_flat[g*DATA_W +: DATA_W] = slot[g];
    end

    // Pointer value after a start clear; read edge selection.
    always_comb begin
        ptr_base = accept ? 1'b0 : rd_ptr;
        sel_now  = rd_fall ? ptr_base : sel_q;
    end

    // Advance the pointer on every read edge, chip-selected or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            rd_ptr <= rd_fall ? ~ptr_base : ptr_base;
            sel_q  <= sel_now;
        end
    end

    // Register the read port; data is forced to zero when not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            dout_oe <= rd_active;
            dout    <= rd_active ? slot[slot_of(pair_s, sel_now)] : '0;
        end
    end

endmodule

// File: rtl/dualsamp_ctrl.sv
// Module: top of the dual simultaneous-sampling converter interface.
// Synchronises the asynchronous pins, detects start and read edges and joins
// the sequencer with the result bank. Assumes conv_tick and samples are in clk.
module dualsamp_ctrl
    import dsc_pkg::*;
#(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CONV_TICKS  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start_n,
    input  logic              pair_sel,
    input  logic              conv_tick,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] samp_a,
    input  logic [DATA_W-1:0] samp_b,
    output logic              busy,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    logic [3:0] pins_s;
    logic       pair_s;
    logic       start_s;
    logic       cs_s;
    logic       rd_s;
    logic       start_prev;
    logic       rd_prev;
    logic       start_fall;
    logic       rd_fall;
    logic       accept;
    logic       wr_en;
    logic       wr_pair;
    logic [DATA_W-1:0] wr_a;
    logic [DATA_W-1:0] wr_b;
    logic       rd_ptr;
    logic [NUM_SLOTS*DATA_W-1:0] bank_flat;

    dsc_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0111)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pair_sel, conv_start_n, cs_n, rd_n}),
        .dout (pins_s)
    );

    assign {pair_s, start_s, cs_s, rd_s} = pins_s;

    // Remember the previous synchronised strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_prev <= 1'b1;
            rd_prev    <= 1'b1;
        end else begin
            start_prev <= start_s;
            rd_prev    <= rd_s;
        end
    end

    assign start_fall = start_prev & ~start_s;
    assign rd_fall    = rd_prev & ~rd_s;

    dsc_seq #(
        .DATA_W    (DATA_W),
        .CONV_TICKS(CONV_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_fall(start_fall),
        .tick      (conv_tick),
        .pair_s    (pair_s),
        .samp_a    (samp_a),
        .samp_b    (samp_b),
        .busy      (busy),
        .accept    (accept),
        .wr_en     (wr_en),
        .wr_pair   (wr_pair),
        .wr_a      (wr_a),
        .wr_b      (wr_b)
    );

    dsc_bank #(
        .DATA_W(DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_pair  (wr_pair),
        .wr_a     (wr_a),
        .wr_b     (wr_b),
        .accept   (accept),
        .rd_fall  (rd_fall),
        .rd_active(~cs_s & ~rd_s),
        .pair_s   (pair_s),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .rd_ptr   (rd_ptr),
        .bank_flat(bank_flat)
    );

endmodule

// File: rtl/dsc_checker.sv
// Module: property checker for dualsamp_ctrl, attached by bind below.
// Assumes start_fall and rd_fall are one-cycle pulses from the edge detector.
module dsc_checker #(
    parameter int unsigned DATA_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_fall,
    input logic                rd_fall,
    input logic                busy,
    input logic                wr_en,
    input logic                rd_ptr,
    input logic [DATA_W-1:0]   dout,
    input logic                dout_oe,
    input logic [4*DATA_W-1:0] bank_flat
);

    // R3: an edge seen while idle raises busy on the next edge.
    a_r3_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fall && !busy) |=> busy);

    // R10: an edge during a conversion neither ends nor restarts it.
    a_r10_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fall && busy && !wr_en) |=> busy);

    // R5: the result write is what ends busy.
    a_r5_write_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !busy);

    // R5: busy never drops without a write.
    a_r5_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en) |=> busy);

    // R6: the bank changes only on a result write.
    a_r6_bank_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_flat));

    // R7: a disabled port shows zero data.
    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));

    // R8: an accepted start without a read edge returns the pointer to A.
    a_r8_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fall && !busy && !rd_fall) |=> (rd_ptr == 1'b0));

    // R9: every read edge flips the pointer unless a start clears it.
    a_r9_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fall && !(start_fall && !busy)) |=> (rd_ptr != $past(rd_ptr)));

endmodule

bind dualsamp_ctrl dsc_checker #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_fall(start_fall),
    .rd_fall   (rd_fall),
    .busy      (busy),
    .wr_en     (wr_en),
    .rd_ptr    (rd_ptr),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .bank_flat (bank_flat)
);

// File: tb/test_dualsamp_ctrl.sv
// Bench: scoreboard for dualsamp_ctrl. Driver tasks queue expected read
// results; a monitor pops and compares them at the sampled read cycle.
module test_dualsamp_ctrl;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_start_n = 1'b1;
    logic         pair_sel = 1'b0;
    logic         conv_tick = 1'b0;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic [W-1:0] samp_a = '0;
    logic [W-1:0] samp_b = '0;
    logic         busy;
    logic [W-1:0] dout;
    logic         dout_oe;

    always #5 clk = ~clk;

    dualsamp_ctrl #(.DATA_W(W)) i_dualsamp_ctrl (
        .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n),
        .pair_sel(pair_sel), .conv_tick(conv_tick), .cs_n(cs_n), .rd_n(rd_n),
        .samp_a(samp_a), .samp_b(samp_b), .busy(busy), .dout(dout),
        .dout_oe(dout_oe)
    );

    int           n_cmp = 0;
    int           n_bad = 0;
    bit           finished = 1'b0;
    bit           sample_req = 1'b0;
    logic [W-1:0] bank_m [4];
    logic         ptr_m = 1'b0;
    logic [W-1:0] cap_a, cap_b;
    logic [W:0]   exp_q [$];
    string        tag_q [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); conv_tick = 1'b1;
            @(negedge clk); conv_tick = 1'b0;
        end
    endtask

    // Accepted start from idle; checks the busy rise cycle (R3).
    task automatic start_conv(input logic [W-1:0] a, input logic [W-1:0] b, input logic pair);
        @(negedge clk); pair_sel = pair; samp_a = a; samp_b = b;
        repeat (3) @(negedge clk);
        conv_start_n = 1'b0; cap_a = a; cap_b = b; ptr_m = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R3 busy before third edge", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R3 busy at third edge", 32'(busy), 32'd1);
        conv_start_n = 1'b1;
    endtask

    // First tick, then disturb samples (R2) and optionally pair_sel (R4).
    task automatic conv_begin(input bit flip);
        tick_n(1);
        samp_a = 12'hA5A; samp_b = 12'h5A5;
        if (flip) pair_sel = ~pair_sel;
    endtask

    // Remaining ticks; busy end on the 14th (R5); update the model (R6).
    task automatic conv_end(input logic pair);
        tick_n(12);
        chk("R5 busy after 13 ticks", 32'(busy), 32'd1);
        tick_n(1);
        chk("R5 busy after 14 ticks", 32'(busy), 32'd0);
        bank_m[{pair, 1'b0}] = cap_a;
        bank_m[{pair, 1'b1}] = cap_b;
    endtask

    // One read strobe; queues the expected port value for the monitor.
    task automatic rd_strobe(input logic cs, input logic pair, input string tag);
        @(negedge clk); pair_sel = pair; cs_n = cs;
        repeat (3) @(negedge clk);
        rd_n = 1'b0;
        if (!cs) exp_q.push_back({1'b1, bank_m[{pair, ptr_m}]});
        else     exp_q.push_back({1'b0, {W{1'b0}}});
        tag_q.push_back(tag);
        ptr_m = ~ptr_m;
        repeat (4) @(posedge clk);
        sample_req = 1'b1;
        wait (sample_req == 1'b0);
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pop one expected item per sample request and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (sample_req) begin
                if (exp_q.size() == 0) begin
                    chk("scoreboard underflow", 32'd1, 32'd0);
                end else begin
                    chk(tag_q.pop_front(), 32'({dout_oe, dout}), 32'(exp_q.pop_front()));
                end
                sample_req = 1'b0;
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) bank_m[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 oe after reset", 32'(dout_oe), 32'd0);
        chk("R1 dout after reset", 32'(dout), 32'd0);
        rd_strobe(1'b0, 1'b0, "R1 A0 zero");
        rd_strobe(1'b0, 1'b1, "R1 B1 zero");

        // Full-scale and negative full-scale into pair 0 (R11, R2, R8).
        start_conv(12'h7FF, 12'h800, 1'b0);
        conv_begin(1'b0);
        conv_end(1'b0);
        rd_strobe(1'b0, 1'b0, "R8 R11 A0 full scale");
        rd_strobe(1'b0, 1'b0, "R8 R11 B0 negative full scale");
        rd_strobe(1'b0, 1'b1, "R6 A1 untouched");
        rd_strobe(1'b0, 1'b1, "R6 B1 untouched");

        // Pair latched at first tick, then pair_sel flipped (R4, R11).
        start_conv(12'h000, 12'hFFF, 1'b1);
        conv_begin(1'b1);
        conv_end(1'b1);
        rd_strobe(1'b0, 1'b1, "R4 R11 A1 midscale");
        rd_strobe(1'b0, 1'b1, "R4 R11 B1 minus one");
        rd_strobe(1'b0, 1'b0, "R6 A0 kept");
        rd_strobe(1'b0, 1'b0, "R6 B0 kept");

        // Unselected read strobe still advances the pointer (R9, R7).
        start_conv(12'h123, 12'h456, 1'b0);
        conv_begin(1'b0);
        conv_end(1'b0);
        rd_strobe(1'b1, 1'b0, "R7 R9 unselected strobe quiet");
        rd_strobe(1'b0, 1'b0, "R9 swapped B0");
        rd_strobe(1'b0, 1'b0, "R9 swapped A0");

        // Chip select alone does not enable the port (R7).
        @(negedge clk); cs_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 oe with cs only", 32'(dout_oe), 32'd0);
        chk("R7 dout with cs only", 32'(dout), 32'd0);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);

        // Start during busy ignored: no recapture, no pointer clear (R10).
        start_conv(12'h321, 12'h654, 1'b1);
        conv_begin(1'b0);
        rd_strobe(1'b0, 1'b0, "R10 A0 read mid conversion");
        @(negedge clk); samp_a = 12'h111; samp_b = 12'h222; conv_start_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 busy after ignored start", 32'(busy), 32'd1);
        conv_start_n = 1'b1;
        repeat (3) @(negedge clk);
        conv_end(1'b1);
        rd_strobe(1'b0, 1'b1, "R10 B1 pointer kept");
        rd_strobe(1'b0, 1'b1, "R10 A1 original sample");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule